// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block drives the control pins of a DDR SDRAM device: clock enable, chip select, row strobe, column strobe, write enable, the bank pins and the address bus. A controller hands it one command at a time over a valid/ready handshake. The sequencer puts the matching pin pattern on the bus for exactly one clock, or for a held window in the case of self-refresh. It then keeps `req_ready` low until the minimum spacing that the command needs has run out. Every cycle that carries no command drives a no-operation pattern. Data strobes, data lines and masks are handled elsewhere.

After reset, the sequencer runs the device start-up on its own. It first holds clock enable low for a fixed number of cycles. It then raises clock enable and drives no-operation cycles for a settle window. Only after that window does it accept requests. Each timing minimum is set in picoseconds together with the clock period. The block turns each one into cycles by rounding up, so any fraction of a period costs a whole extra cycle. A power-up request restarts the same start-up sequence at any time.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and for CKE_LOW_CYC (10) cycles after the last reset edge, `sd_cke` is 0, the command pins show no-operation (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1, bank and address 0) and `req_ready` is 0.
- R2: After the clock-enable-low phase, `sd_cke` is 1 and no-operation is driven for ceil(INIT_NOP_PS/CLK_PS) (80) cycles with `req_ready` low. Requests presented in that time leave the pins unchanged. `req_ready` rises in the cycle that follows.
- R3: Op codes 1 and 2 load a mode register. All four command pins are 0, `sd_cke` is 1, `sd_a` equals `req_addr`, and `sd_ba` is 0 for op 1 (main register) or 1 for op 2 (extended register). The next command follows ceil(T_MRD_PS/CLK_PS) (2) cycles later.
- R4: Op code 3 refreshes. `sd_cs_n`, `sd_ras_n` and `sd_cas_n` are 0, `sd_we_n` is 1 and `sd_cke` is 1, with bank and address 0. The spacing to the next command is ceil(T_RFC_PS/CLK_PS) (14) cycles.
- R5: Op code 4 precharges. Pins are cs 0, ras 0, cas 1, we 0. `sd_ba` carries `req_bank`, address bit 10 carries `req_all` (1 means every bank), and all other address bits are 0. The spacing is ceil(12500/5000) = 3 cycles, so the fractional part adds a cycle.
- R6: Op code 5 activates. Pins are cs 0, ras 0, cas 1, we 1, with `sd_a` = `req_addr` (row) and `sd_ba` = `req_bank`. The spacing is ceil(T_RCD_PS/CLK_PS) (3) cycles.
- R7: Op code 6 terminates a burst. Pins are cs 0, ras 1, cas 1, we 0, with bank and address 0. `req_ready` stays high, so a new command can appear on the very next cycle.
- R8: Op code 7 enters self-refresh. The refresh pattern with `sd_cke` 0 is held for `req_hold` cycles, where 0 counts as 1. Then `sd_cke` returns to 1 with no-operation. The next command comes no earlier than ceil(T_XSR_PS/CLK_PS) (15) cycles after clock enable rises.
- R9: Op code 0 restarts start-up. From the cycle after acceptance, the R1 clock-enable-low phase and the R2 settle window repeat, with `req_ready` low throughout.
- R10: An accepted command appears on the pins in the cycle after the edge where `req_valid` and `req_ready` are both high. For a spacing of G cycles, `req_ready` is low for G-1 cycles starting with that command cycle.
- R11: Every cycle with clock enable high that is not a command cycle drives no-operation with bank and address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Sequencer can take a command this cycle |
| req_op | input | 3 | Command code (0 start-up, 1 mode, 2 extended mode, 3 refresh, 4 precharge, 5 activate, 6 burst stop, 7 self-refresh) |
| req_bank | input | BANK_W | Bank for precharge and activate |
| req_addr | input | ADDR_W | Row for activate, register value for mode loads |
| req_all | input | 1 | Precharge every bank |
| req_hold | input | HOLD_W | Self-refresh hold length in cycles |
| sd_cke | output | 1 | Clock enable to device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank pins |
| sd_a | output | ADDR_W | Address pins |

## Verification
Directed sequences cover both mode-register banks, precharge of one bank and of all banks, and a burst stop followed at once by an activate. They also cover self-refresh holds of 0, 1 and several cycles, and a start-up request issued mid-run. These separate an encoding slip on a single pin or field from a wrong spacing and from an off-by-one in a hold window. A seeded random stream then mixes all eight op codes with idle gaps of zero to two cycles. Back-to-back traffic shows whether `req_ready` rises exactly when the spacing allows, and the idle cycles show whether no-operation is driven between commands. Requests held during start-up, and a reset in mid-traffic, test that nothing leaks onto the pins before the settle window ends.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    typedef enum logic [2:0] {
        OP_POWER_UP     = 3'd0,
        OP_LOAD_MODE    = 3'd1,
        OP_LOAD_EXT     = 3'd2,
        OP_REFRESH      = 3'd3,
        OP_PRECHARGE    = 3'd4,
        OP_ACTIVATE     = 3'd5,
        OP_BURST_STOP   = 3'd6,
        OP_SELF_REFRESH = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        ST_PU_LOW = 2'd0,
        ST_PU_NOP = 2'd1,
        ST_RUN    = 2'd2,
        ST_SREF   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_MRS   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t PINS_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_PRE   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_ACT   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_BST   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    // Round a time in picoseconds up to whole clock periods, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder
    import ddr_seq_pkg::*;
#(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned AP_BIT = 10
) (
    input  seq_op_e             op,
    input  logic [BANK_W-1:0]   bank,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                all_banks,
    output cmd_pins_t           pins,
    output logic                cke,
    output logic [BANK_W-1:0]   ba,
    output logic [ADDR_W-1:0]   a
);

    always_comb begin
        pins = PINS_NOP;
        cke  = 1'b1;
        ba   = '0;
        a    = '0;
        unique case (op)
            OP_POWER_UP: begin
                cke = 1'b0;
            end
            OP_LOAD_MODE: begin
                pins = PINS_MRS;
                ba   = BANK_W'(0);
                a    = addr;
            end
            OP_LOAD_EXT: begin
                pins = PINS_MRS;
                ba   = BANK_W'(1);
                a    = addr;
            end
            OP_REFRESH: begin
                pins = PINS_REF;
            end
            OP_PRECHARGE: begin
                pins      = PINS_PRE;
                ba        = bank;
                a[AP_BIT] = all_banks;
            end
            OP_ACTIVATE: begin
                pins = PINS_ACT;
                ba   = bank;
                a    = addr;
            end
            OP_BURST_STOP: begin
                pins = PINS_BST;
            end
            OP_SELF_REFRESH: begin
                pins = PINS_REF;
                cke  = 1'b0;
            end
            default: begin
                pins = PINS_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_gap_table.sv
module ddr_gap_table
    import ddr_seq_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MRD_CYC = 2,
    parameter int unsigned RFC_CYC = 14,
    parameter int unsigned RP_CYC  = 3,
    parameter int unsigned RCD_CYC = 3
) (
    input  seq_op_e          op,
    output logic [CNT_W-1:0] wait_cyc
);

    // Cycles of held-off ready after the command cycle: spacing minus one.
    always_comb begin
        unique case (op)
            OP_LOAD_MODE,
            OP_LOAD_EXT:  wait_cyc = CNT_W'(MRD_CYC - 1);
            OP_REFRESH:   wait_cyc = CNT_W'(RFC_CYC - 1);
            OP_PRECHARGE: wait_cyc = CNT_W'(RP_CYC - 1);
            OP_ACTIVATE:  wait_cyc = CNT_W'(RCD_CYC - 1);
            default:      wait_cyc = '0;
        endcase
    end

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned HOLD_W      = 8,
    parameter int unsigned AP_BIT      = 10,
    parameter int unsigned CLK_PS      = 5000,
    parameter int unsigned CKE_LOW_CYC = 10,
    parameter int unsigned INIT_NOP_PS = 400000,
    parameter int unsigned T_MRD_PS    = 10000,
    parameter int unsigned T_RFC_PS    = 70000,
    parameter int unsigned T_RP_PS     = 12500,
    parameter int unsigned T_RCD_PS    = 15000,
    parameter int unsigned T_XSR_PS    = 75000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_all,
    input  logic [HOLD_W-1:0] req_hold,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_a
);

    localparam int unsigned MRD_CYC  = ps_to_cycles(T_MRD_PS, CLK_PS);
    localparam int unsigned RFC_CYC  = ps_to_cycles(T_RFC_PS, CLK_PS);
    localparam int unsigned RP_CYC   = ps_to_cycles(T_RP_PS, CLK_PS);
    localparam int unsigned RCD_CYC  = ps_to_cycles(T_RCD_PS, CLK_PS);
    localparam int unsigned XSR_CYC  = ps_to_cycles(T_XSR_PS, CLK_PS);
    localparam int unsigned INIT_CYC = ps_to_cycles(INIT_NOP_PS, CLK_PS);
    localparam int unsigned LOW_CYC  = (CKE_LOW_CYC == 0) ? 1 : CKE_LOW_CYC;

    localparam int unsigned MAX_GAP  = max2(max2(max2(MRD_CYC, RFC_CYC), max2(RP_CYC, RCD_CYC)),
                                            max2(max2(XSR_CYC, INIT_CYC), LOW_CYC));
    localparam int unsigned CNT_W    = max2($clog2(MAX_GAP + 1), HOLD_W);

    typedef struct packed {
        seq_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               cke;
        cmd_pins_t          pins;
        logic [BANK_W-1:0]  ba;
        logic [ADDR_W-1:0]  a;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    seq_op_e             op_s;
    cmd_pins_t           enc_pins;
    logic                enc_cke;
    logic [BANK_W-1:0]   enc_ba;
    logic [ADDR_W-1:0]   enc_a;
    logic [CNT_W-1:0]    gap_wait;
    logic                accept;

    assign op_s = seq_op_e'(req_op);

    ddr_cmd_encoder #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W),
        .AP_BIT (AP_BIT)
    ) enc_i (
        .op        (op_s),
        .bank      (req_bank),
        .addr      (req_addr),
        .all_banks (req_all),
        .pins      (enc_pins),
        .cke       (enc_cke),
        .ba        (enc_ba),
        .a         (enc_a)
    );

    ddr_gap_table #(
        .CNT_W   (CNT_W),
        .MRD_CYC (MRD_CYC),
        .RFC_CYC (RFC_CYC),
        .RP_CYC  (RP_CYC),
        .RCD_CYC (RCD_CYC)
    ) gap_i (
        .op       (op_s),
        .wait_cyc (gap_wait)
    );

    assign req_ready = (r_q.st == ST_RUN) && (r_q.cnt == '0);
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d      = r_q;
        r_d.pins = PINS_NOP;
        r_d.cke  = 1'b1;
        r_d.ba   = '0;
        r_d.a    = '0;
        unique case (r_q.st)
            ST_PU_LOW: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                    r_d.cke = 1'b0;
                end else begin
                    r_d.st  = ST_PU_NOP;
                    r_d.cnt = CNT_W'(INIT_CYC - 1);
                end
            end
            ST_PU_NOP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    r_d.pins = enc_pins;
                    r_d.cke  = enc_cke;
                    r_d.ba   = enc_ba;
                    r_d.a    = enc_a;
                    unique case (op_s)
                        OP_POWER_UP: begin
                            r_d.st  = ST_PU_LOW;
                            r_d.cnt = CNT_W'(LOW_CYC - 1);
                        end
                        OP_SELF_REFRESH: begin
                            r_d.st  = ST_SREF;
                            r_d.cnt = (req_hold == '0) ? '0
                                    : (CNT_W'(req_hold) - CNT_W'(1));
                        end
                        default: begin
                            r_d.cnt = gap_wait;
                        end
                    endcase
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_SREF: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt  = r_q.cnt - CNT_W'(1);
                    r_d.pins = PINS_REF;
                    r_d.cke  = 1'b0;
                end else begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = CNT_W'(XSR_CYC - 1);
                end
            end
            default: begin
                r_d.st = ST_PU_LOW;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st:   ST_PU_LOW,
                     cnt:  CNT_W'(LOW_CYC - 1),
                     cke:  1'b0,
                     pins: PINS_NOP,
                     ba:   '0,
                     a:    '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_cke   = r_q.cke;
    assign sd_cs_n  = r_q.pins.cs_n;
    assign sd_ras_n = r_q.pins.ras_n;
    assign sd_cas_n = r_q.pins.cas_n;
    assign sd_we_n  = r_q.pins.we_n;
    assign sd_ba    = r_q.ba;
    assign sd_a     = r_q.a;

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk
    import ddr_seq_pkg::*;
#(
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned CLK_PS  = 5000,
    parameter int unsigned T_RP_PS = 12500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [BANK_W-1:0] req_bank,
    input logic [ADDR_W-1:0] req_addr,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ADDR_W-1:0] sd_a
);

    localparam int unsigned RP_CYC = ps_to_cycles(T_RP_PS, CLK_PS);
    localparam logic        RP_MULTI = (RP_CYC > 1);

    logic take;
    logic pins_nop;

    assign take     = req_valid && req_ready;
    assign pins_nop = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n
                      && (sd_ba == '0) && (sd_a == '0);

    // R1: clock enable low never coincides with ready
    p_cke_low_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> !req_ready);

    // R3: extended-register load selects bank 1 with all strobes low
    p_ext_mode_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_LOAD_EXT) |=>
            (sd_ba == BANK_W'(1)) && !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n
            && (sd_a == $past(req_addr)));

    // R5: precharge holds off ready in the following cycle when spacing exceeds one
    p_rp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (RP_MULTI && take && req_op == OP_PRECHARGE) |=> !req_ready);

    // R6: activate pattern with row and bank passed through
    p_act_encode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_ACTIVATE) |=>
            !sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n && sd_cke
            && (sd_a == $past(req_addr)) && (sd_ba == $past(req_bank)));

    // R7: burst stop leaves ready high
    p_bst_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == OP_BURST_STOP) |=> req_ready);

    // R8: clock enable comes back with a no-operation pattern
    p_cke_rise_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> pins_nop);

    // R11: no accepted command means no-operation whenever clock enable is high
    p_nop_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!sd_cke || pins_nop));

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
    .BANK_W  (BANK_W),
    .ADDR_W  (ADDR_W),
    .CLK_PS  (CLK_PS),
    .T_RP_PS (T_RP_PS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_a      (sd_a)
);

// File: tb/ddr_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_seq_tb_top;

    localparam int L_CYC   = 10;
    localparam int I_CYC   = 80;
    localparam int MRD     = 2;
    localparam int RFC     = 14;
    localparam int RP      = 3;
    localparam int RCD     = 3;
    localparam int XSR     = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_addr = 13'd0;
    logic        req_all = 1'b0;
    logic [7:0]  req_hold = 8'd0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_seq dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_bank (req_bank), .req_addr (req_addr),
        .req_all (req_all), .req_hold (req_hold),
        .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_ba (sd_ba), .sd_a (sd_a)
    );

    function automatic logic [19:0] bus_now();
        return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_a};
    endfunction

    localparam logic [19:0] BUS_NOP_HI = {5'b10111, 2'd0, 13'd0};
    localparam logic [19:0] BUS_NOP_LO = {5'b00111, 2'd0, 13'd0};

    function automatic logic [19:0] exp_bus(int op, logic [1:0] bank, logic [12:0] addr, logic all);
        case (op)
            0: return BUS_NOP_LO;
            1: return {5'b10000, 2'd0, addr};
            2: return {5'b10000, 2'd1, addr};
            3: return {5'b10001, 2'd0, 13'd0};
            4: return {5'b10010, bank, 13'(all) << 10};
            5: return {5'b10011, bank, addr};
            6: return {5'b10110, 2'd0, 13'd0};
            default: return {5'b00001, 2'd0, 13'd0};
        endcase
    endfunction

    function automatic int exp_wait(int op);
        case (op)
            1, 2: return MRD - 1;
            3:    return RFC - 1;
            4:    return RP - 1;
            5:    return RCD - 1;
            default: return 0;
        endcase
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R9";
            1, 2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Starts at a negedge in the first cycle of the clock-enable-low phase.
    task automatic check_init(string tag);
        int low_n = 0;
        int hi_n = 0;
        bit ok = 1'b1;
        while (sd_cke == 1'b0) begin
            if (bus_now() != BUS_NOP_LO || req_ready) ok = 1'b0;
            low_n++;
            @(negedge clk);
        end
        while (!req_ready) begin
            if (bus_now() != BUS_NOP_HI) ok = 1'b0;
            hi_n++;
            @(negedge clk);
        end
        chk(tag, "R1 cke low cycles", low_n, L_CYC);
        chk(tag, "R2 settle nop cycles", hi_n, I_CYC);
        chk(tag, "R2 pins nop and not ready during start-up", ok, 1);
    endtask

    // Called at a negedge where req_ready is high.
    task automatic issue(int op, logic [1:0] bank, logic [12:0] addr, logic all, logic [7:0] hold);
        string tag;
        tag = op_tag(op);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_bank  = bank;
        req_addr  = addr;
        req_all   = all;
        req_hold  = hold;
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 0) begin
            check_init("R9");
        end else if (op == 7) begin
            int n = 0;
            int w = 0;
            bit ok = 1'b1;
            while (sd_cke == 1'b0) begin
                if (bus_now() != exp_bus(7, 0, 0, 0) || req_ready) ok = 1'b0;
                n++;
                @(negedge clk);
            end
            chk("R8", "self-refresh hold cycles", n, (hold == 0) ? 1 : int'(hold));
            chk("R8", "refresh with cke low during hold", ok, 1);
            ok = 1'b1;
            while (!req_ready) begin
                if (bus_now() != BUS_NOP_HI) ok = 1'b0;
                w++;
                @(negedge clk);
            end
            chk("R8", "ready hold-off after cke rise", w, XSR - 1);
            chk("R11", "nop after self-refresh exit", ok, 1);
        end else begin
            int w = 0;
            bit ok = 1'b1;
            chk(tag, "R10 command pins", bus_now(), exp_bus(op, bank, addr, all));
            while (!req_ready) begin
                w++;
                @(negedge clk);
                if (bus_now() != BUS_NOP_HI) ok = 1'b0;
            end
            chk(tag, "R10 ready low cycles", w, exp_wait(op));
            chk("R11", "nop during spacing", ok, 1);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R11", "idle nop", bus_now(), BUS_NOP_HI);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1", "reset cke", sd_cke, 0);
        chk("R1", "reset ready", req_ready, 0);
        chk("R1", "reset pins", bus_now(), BUS_NOP_LO);

        // Requests held during start-up must not reach the pins (R2).
        req_valid = 1'b1;
        req_op    = 3'd5;
        req_addr  = 13'h0abc;
        req_bank  = 2'd2;
        rst_n     = 1'b1;
        check_init("R2");
        req_valid = 1'b0;

        // Directed corner cases.
        issue(1, 2'd3, 13'h1234, 1'b0, 8'd0);
        issue(2, 2'd0, 13'h0401, 1'b0, 8'd0);
        issue(4, 2'd1, 13'h1fff, 1'b0, 8'd0);
        issue(4, 2'd2, 13'h0000, 1'b1, 8'd0);
        issue(6, 2'd3, 13'h1fff, 1'b1, 8'd0);
        chk("R7", "ready right after burst stop", req_ready, 1);
        issue(5, 2'd3, 13'h1555, 1'b0, 8'd0);
        issue(3, 2'd0, 13'h0000, 1'b0, 8'd0);
        issue(7, 2'd0, 13'h0000, 1'b0, 8'd0);
        issue(7, 2'd0, 13'h0000, 1'b0, 8'd1);
        issue(7, 2'd0, 13'h0000, 1'b0, 8'd6);
        idle(3);
        issue(0, 2'd0, 13'h0000, 1'b0, 8'd0);

        // Random traffic.
        for (int k = 0; k < 220; k++) begin
            int op;
            op = int'($urandom_range(0, 15));
            if (op > 7) op = 1 + (op % 7);
            issue(op, 2'($urandom_range(0, 3)), 13'($urandom_range(0, 8191)),
                  1'($urandom_range(0, 1)), 8'($urandom_range(0, 12)));
            idle(int'($urandom_range(0, 2)));
        end

        // Reset in the middle of traffic.
        issue(5, 2'd1, 13'h0077, 1'b0, 8'd0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "mid-run reset cke", sd_cke, 0);
        rst_n = 1'b1;
        check_init("R1");
        issue(4, 2'd0, 13'h0000, 1'b1, 8'd0);

        summary();
        $finish;
    end

endmodule